// File: doc/BRIEF.md
# Tagged Request Arbiter Switch

The switch joins several requester ports onto one downstream request channel and steers each returning response back to the requester that issued it. Every cycle in which the switch is ready, the requests that are valid on its inputs are sampled together as one snapshot batch. The batch holds each requester's tag and data plus a bitmask of which ports took part, and it enters a small batch queue. Only the oldest batch is arbitrated. One request leaves it per grant, and the batch is retired once its mask is empty.

Selection uses a rotating search that starts at an arbitration cursor. In rotate mode the cursor moves just past each winner, which gives round-robin fairness. In fixed mode the cursor stays at zero, so lower port numbers always win. The winning port number is placed below the request tag. On the return path the switch reads those low bits to choose the destination port and removes them before it forwards the response.

Top module: `tagged_arb_switch`

## Requirements
- R1: In a cycle where `req_ready_o` is high, every request with its `req_valid_i` bit set is captured into one batch, and each captured request is forwarded downstream exactly once. A cycle with no valid inputs creates no batch and produces nothing downstream.
- R2: Requests leave one per downstream handshake. Every request of an earlier batch is forwarded before any request of a later batch.
- R3: In rotate mode the search inside the head batch starts at the cursor and goes through ports in increasing number modulo N. After a grant to port k the cursor becomes k+1, and a grant to port N-1 returns it to 0.
- R4: In fixed mode the lowest-numbered pending port of the head batch always wins.
- R5: Let S be ceil(log2 N), with S = 0 when N = 1. The downstream tag is TAG_W+S bits wide and equals the requester tag shifted left by S with the port number in the low S bits. The data passes through unchanged.
- R6: Suppose the switch is empty and the downstream side is ready. A lone request that is presented in cycle t is then valid on `req_valid_o` in cycle t+1+REQ_LAT and not earlier.
- R7: While `req_valid_o` is high and `req_ready_i` is low, the downstream valid, tag and data hold their values.
- R8: `req_ready_o` is low while the batch queue holds FIFO_DEPTH batches. Requests presented while it is low are not captured.
- R9: A response whose low S tag bits name port p < N shows up one cycle later as a single-cycle pulse on bit p of `rsp_valid_o`. It carries the tag shifted right by S and the data unchanged, and no other bit of `rsp_valid_o` is set.
- R10: A response whose low S tag bits name a port number of N or above is dropped, and `rsp_valid_o` stays all zero.
- R11: Reset is synchronous and active high. After reset `req_valid_o` and `rsp_valid_o` are low, `req_ready_o` is high and the cursor is 0, so the first grant search starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_REQ | Per-requester request valid |
| req_ready_o | output | 1 | Switch can capture a batch this cycle |
| req_tag_i | input | N_REQ*TAG_W | Requester tags, port p at bits p*TAG_W |
| req_data_i | input | N_REQ*DATA_W | Requester data, port p at bits p*DATA_W |
| req_valid_o | output | 1 | Downstream request valid |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_tag_o | output | TAG_W+S | Extended tag carrying the port number in its low bits |
| req_data_o | output | DATA_W | Downstream request data |
| rsp_valid_i | input | 1 | Returning response valid |
| rsp_tag_i | input | TAG_W+S | Returning extended tag |
| rsp_data_i | input | DATA_W | Returning response data |
| rsp_valid_o | output | N_REQ | One-hot response valid per requester |
| rsp_tag_o | output | TAG_W | Response tag with the port bits removed |
| rsp_data_o | output | DATA_W | Response data |

## Verification
The bench builds two copies of the switch. The first has four ports, rotate mode, a two-stage request delay and a four-batch queue. It reaches cursor wrap from port 3, several batches waiting behind a busy head, and a full queue with the downstream held off. The second has three ports, fixed mode, a one-stage delay and a two-batch queue. Its two-bit port field has an unused code (3), which makes the dropped-response case reachable, and it shows that low ports win regardless of history.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_kind_e;

    // number of tag bits spent on the port number
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/tsw_batch_fifo.sv
module tsw_batch_fifo #(
    parameter int N     = 4,
    parameter int PW    = 14,
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_i,
    input  logic [N-1:0]    push_mask_i,
    input  logic [N*PW-1:0] push_data_i,
    input  logic            take_i,
    input  logic [IW-1:0]   take_idx_i,
    output logic [N-1:0]    head_mask_o,
    output logic [N*PW-1:0] head_data_o,
    output logic            full_o
);

    typedef struct packed {
        logic [DEPTH-1:0][N-1:0]    mask;
        logic [DEPTH-1:0][N*PW-1:0] data;
        logic [PTR_W-1:0]           rd;
        logic [PTR_W-1:0]           wr;
        logic [CNT_W-1:0]           cnt;
    } fifo_s;

    fifo_s st_d, st_q;

    logic          empty;
    logic          do_push;
    logic          do_pop;
    logic [N-1:0]  remaining;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        empty     = (st_q.cnt == '0);
        full_o    = (st_q.cnt == CNT_W'(DEPTH));
        do_push   = push_i && !full_o && (push_mask_i != '0);
        remaining = st_q.mask[st_q.rd] & ~(N'(1) << take_idx_i);
        do_pop    = take_i && !empty && (remaining == '0);

        // clear the granted bit in the head batch
        if (take_i && !empty) begin
            st_d.mask[st_q.rd] = remaining;
        end
        if (do_push) begin
            st_d.mask[st_q.wr] = push_mask_i;
            st_d.data[st_q.wr] = push_data_i;
            st_d.wr            = ptr_next(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);

        head_mask_o = empty ? '0 : st_q.mask[st_q.rd];
        head_data_o = st_q.data[st_q.rd];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsw_rot_pick.sv
module tsw_rot_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask_i,
    input  logic [IW-1:0] start_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    int pos;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pos     = 0;
        for (int i = 0; i < N; i++) begin
            pos = int'(start_i) + i;
            if (pos >= N) begin
                pos = pos - N;
            end
            if (!found_o && mask_i[pos]) begin
                found_o = 1'b1;
                idx_o   = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/tsw_rsp_route.sv
module tsw_rsp_route #(
    parameter int N      = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    parameter int SHIFT  = 2,
    localparam int SEL_W = (SHIFT > 0) ? SHIFT : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rsp_valid_i,
    input  logic [TAG_W+SHIFT-1:0] rsp_tag_i,
    input  logic [DATA_W-1:0]      rsp_data_i,
    output logic [N-1:0]           rsp_valid_o,
    output logic [TAG_W-1:0]       rsp_tag_o,
    output logic [DATA_W-1:0]      rsp_data_o
);

    typedef struct packed {
        logic [N-1:0]      vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } route_s;

    route_s rt_d, rt_q;

    logic [SEL_W-1:0] dest;
    logic [TAG_W-1:0] tag_strip;

    generate
        if (SHIFT > 0) begin : g_split
            assign dest      = rsp_tag_i[SHIFT-1:0];
            assign tag_strip = rsp_tag_i[TAG_W+SHIFT-1:SHIFT];
        end else begin : g_single
            assign dest      = '0;
            assign tag_strip = rsp_tag_i;
        end
    endgenerate

    always_comb begin
        rt_d     = rt_q;
        rt_d.vld = '0;
        if (rsp_valid_i) begin
            rt_d.tag  = tag_strip;
            rt_d.data = rsp_data_i;
            for (int p = 0; p < N; p++) begin
                if (int'(dest) == p) begin
                    rt_d.vld[p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign rsp_valid_o = rt_q.vld;
    assign rsp_tag_o   = rt_q.tag;
    assign rsp_data_o  = rt_q.data;

endmodule

// File: rtl/tagged_arb_switch.sv
module tagged_arb_switch #(
    parameter int                  N_REQ      = 4,
    parameter int                  TAG_W      = 6,
    parameter int                  DATA_W     = 8,
    parameter int                  FIFO_DEPTH = 4,
    parameter int                  REQ_LAT    = 1,
    parameter tsw_pkg::arb_kind_e  ARB        = tsw_pkg::ARB_ROTATE,
    localparam int SHIFT  = tsw_pkg::idx_bits(N_REQ),
    localparam int SEL_W  = (SHIFT > 0) ? SHIFT : 1,
    localparam int OTAG_W = TAG_W + SHIFT,
    localparam int PW     = TAG_W + DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_REQ-1:0]          req_valid_i,
    output logic                      req_ready_o,
    input  logic [N_REQ*TAG_W-1:0]    req_tag_i,
    input  logic [N_REQ*DATA_W-1:0]   req_data_i,
    output logic                      req_valid_o,
    input  logic                      req_ready_i,
    output logic [OTAG_W-1:0]         req_tag_o,
    output logic [DATA_W-1:0]         req_data_o,
    input  logic                      rsp_valid_i,
    input  logic [OTAG_W-1:0]         rsp_tag_i,
    input  logic [DATA_W-1:0]         rsp_data_i,
    output logic [N_REQ-1:0]          rsp_valid_o,
    output logic [TAG_W-1:0]          rsp_tag_o,
    output logic [DATA_W-1:0]         rsp_data_o
);

    typedef struct packed {
        logic [SEL_W-1:0]                 cursor;
        logic [REQ_LAT-1:0]               vld;
        logic [REQ_LAT-1:0][OTAG_W-1:0]   tag;
        logic [REQ_LAT-1:0][DATA_W-1:0]   data;
    } out_s;

    out_s st_d, st_q;

    logic [N_REQ*PW-1:0] push_data;
    logic [N_REQ*PW-1:0] head_data;
    logic [N_REQ-1:0]    head_mask;
    logic                fifo_full;
    logic                found;
    logic [SEL_W-1:0]    pick_idx;
    logic                advance;
    logic                grant;
    logic [PW-1:0]       sel_pay;
    logic [OTAG_W-1:0]   out_tag;
    logic [SEL_W-1:0]    arb_cursor;

    // per-port payload packing: {tag, data}
    generate
        for (genvar p = 0; p < N_REQ; p++) begin : g_pack
            assign push_data[p*PW +: PW] = {req_tag_i[p*TAG_W +: TAG_W],
                                            req_data_i[p*DATA_W +: DATA_W]};
        end
    endgenerate

    tsw_batch_fifo #(
        .N     (N_REQ),
        .PW    (PW),
        .DEPTH (FIFO_DEPTH),
        .IW    (SEL_W)
    ) i_batch_fifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (req_ready_o),
        .push_mask_i (req_valid_i),
        .push_data_i (push_data),
        .take_i      (grant),
        .take_idx_i  (pick_idx),
        .head_mask_o (head_mask),
        .head_data_o (head_data),
        .full_o      (fifo_full)
    );

    tsw_rot_pick #(
        .N  (N_REQ),
        .IW (SEL_W)
    ) i_rot_pick (
        .mask_i  (head_mask),
        .start_i (st_q.cursor),
        .found_o (found),
        .idx_o   (pick_idx)
    );

    assign sel_pay = head_data[int'(pick_idx)*PW +: PW];

    generate
        if (SHIFT > 0) begin : g_tag_ext
            assign out_tag = {sel_pay[PW-1:DATA_W], pick_idx};
        end else begin : g_tag_pass
            assign out_tag = sel_pay[PW-1:DATA_W];
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        advance = !st_q.vld[REQ_LAT-1] || req_ready_i;
        grant   = found && advance;

        if (advance) begin
            st_d.vld[0]  = grant;
            st_d.tag[0]  = out_tag;
            st_d.data[0] = sel_pay[DATA_W-1:0];
            for (int k = 1; k < REQ_LAT; k++) begin
                st_d.vld[k]  = st_q.vld[k-1];
                st_d.tag[k]  = st_q.tag[k-1];
                st_d.data[k] = st_q.data[k-1];
            end
        end

        if (grant && (ARB == tsw_pkg::ARB_ROTATE)) begin
            st_d.cursor = (pick_idx == SEL_W'(N_REQ - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arb_cursor  = st_q.cursor;
    assign req_ready_o = !fifo_full;
    assign req_valid_o = st_q.vld[REQ_LAT-1];
    assign req_tag_o   = st_q.tag[REQ_LAT-1];
    assign req_data_o  = st_q.data[REQ_LAT-1];

    tsw_rsp_route #(
        .N      (N_REQ),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .SHIFT  (SHIFT)
    ) i_rsp_route (
        .clk         (clk),
        .rst         (rst),
        .rsp_valid_i (rsp_valid_i),
        .rsp_tag_i   (rsp_tag_i),
        .rsp_data_i  (rsp_data_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_tag_o   (rsp_tag_o),
        .rsp_data_o  (rsp_data_o)
    );

endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
    parameter int N_REQ  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    parameter bit ROTATE = 1'b1,
    localparam int SHIFT  = tsw_pkg::idx_bits(N_REQ),
    localparam int SEL_W  = (SHIFT > 0) ? SHIFT : 1,
    localparam int OTAG_W = TAG_W + SHIFT
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [OTAG_W-1:0] req_tag_o,
    input logic [DATA_W-1:0] req_data_o,
    input logic              rsp_valid_i,
    input logic [OTAG_W-1:0] rsp_tag_i,
    input logic [N_REQ-1:0]  rsp_valid_o,
    input logic              grant_i,
    input logic [SEL_W-1:0]  grant_idx_i,
    input logic [SEL_W-1:0]  cursor_i
);

    logic [SEL_W-1:0] rsp_dest;
    logic             rsp_in_range;

    generate
        if (SHIFT > 0) begin : g_dest
            assign rsp_dest = rsp_tag_i[SHIFT-1:0];
        end else begin : g_nodest
            assign rsp_dest = '0;
        end
    endgenerate

    assign rsp_in_range = int'(rsp_dest) < N_REQ;

    // R7: a stalled downstream request holds
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_tag_o) && $stable(req_data_o));

    // R9: at most one destination port per response
    a_r9_single_dest: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid_o));

    // R9: a routable response shows up on the next cycle
    a_r9_rsp_next_cycle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_i && rsp_in_range |=> rsp_valid_o != '0);

    // R10: no response output without a routable input
    a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid_i && rsp_in_range) |=> rsp_valid_o == '0);

    // R8: a full queue stays full until a grant frees space
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
        !req_ready_o && !grant_i |=> !req_ready_o);

    generate
        if (ROTATE) begin : g_rot_chk
            // R3: a grant on the last port wraps the cursor to zero
            a_r3_cursor_wrap: assert property (@(posedge clk) disable iff (rst)
                grant_i && (grant_idx_i == SEL_W'(N_REQ - 1)) |=> cursor_i == '0);
        end
        if (SHIFT > 0) begin : g_idx_chk
            // R5: the port field of an outgoing tag names an existing port
            a_r5_index_in_range: assert property (@(posedge clk) disable iff (rst)
                req_valid_o |-> int'(req_tag_o[SEL_W-1:0]) < N_REQ);
        end
    endgenerate

endmodule

bind tagged_arb_switch tsw_checker #(
    .N_REQ  (N_REQ),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W),
    .ROTATE (ARB == tsw_pkg::ARB_ROTATE)
) i_tsw_checker (
    .clk         (clk),
    .rst         (rst),
    .req_ready_o (req_ready_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_tag_o   (req_tag_o),
    .req_data_o  (req_data_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_tag_i   (rsp_tag_i),
    .rsp_valid_o (rsp_valid_o),
    .grant_i     (grant),
    .grant_idx_i (pick_idx),
    .cursor_i    (arb_cursor)
);

// File: tb/test_tagged_arb_switch.sv
`timescale 1ns/1ps
module test_tagged_arb_switch;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // instance A: 4 ports, rotate, 2-stage delay, 4-batch queue
    logic [3:0]  a_rv = '0;
    logic        a_rdy;
    logic [23:0] a_rt = '0;
    logic [31:0] a_rd = '0;
    logic        a_ov;
    logic        a_ordy = 1'b1;
    logic [7:0]  a_ot, a_od;
    logic        a_sv = 1'b0;
    logic [7:0]  a_st = '0, a_sd = '0;
    logic [3:0]  a_pv;
    logic [5:0]  a_pt;
    logic [7:0]  a_pd;

    // instance B: 3 ports, fixed, 1-stage delay, 2-batch queue
    logic [2:0]  b_rv = '0;
    logic        b_rdy;
    logic [17:0] b_rt = '0;
    logic [23:0] b_rd = '0;
    logic        b_ov;
    logic        b_ordy = 1'b1;
    logic [7:0]  b_ot, b_od;
    logic        b_sv = 1'b0;
    logic [7:0]  b_st = '0, b_sd = '0;
    logic [2:0]  b_pv;
    logic [5:0]  b_pt;
    logic [7:0]  b_pd;

    tagged_arb_switch #(
        .N_REQ(4), .TAG_W(6), .DATA_W(8), .FIFO_DEPTH(4), .REQ_LAT(2),
        .ARB(tsw_pkg::ARB_ROTATE)
    ) i_tagged_arb_switch (
        .clk(clk), .rst(rst),
        .req_valid_i(a_rv), .req_ready_o(a_rdy), .req_tag_i(a_rt), .req_data_i(a_rd),
        .req_valid_o(a_ov), .req_ready_i(a_ordy), .req_tag_o(a_ot), .req_data_o(a_od),
        .rsp_valid_i(a_sv), .rsp_tag_i(a_st), .rsp_data_i(a_sd),
        .rsp_valid_o(a_pv), .rsp_tag_o(a_pt), .rsp_data_o(a_pd)
    );

    tagged_arb_switch #(
        .N_REQ(3), .TAG_W(6), .DATA_W(8), .FIFO_DEPTH(2), .REQ_LAT(1),
        .ARB(tsw_pkg::ARB_FIXED)
    ) i_tagged_arb_switch_fixed (
        .clk(clk), .rst(rst),
        .req_valid_i(b_rv), .req_ready_o(b_rdy), .req_tag_i(b_rt), .req_data_i(b_rd),
        .req_valid_o(b_ov), .req_ready_i(b_ordy), .req_tag_o(b_ot), .req_data_o(b_od),
        .rsp_valid_i(b_sv), .rsp_tag_i(b_st), .rsp_data_i(b_sd),
        .rsp_valid_o(b_pv), .rsp_tag_o(b_pt), .rsp_data_o(b_pd)
    );

    logic [15:0] qa[$];
    logic [15:0] qb[$];
    int a_cur = 0;
    int a_mode = 0;   // 0 ready, 1 held off, 2 random
    int b_mode = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input logic [7:0] seed, input int p);
        return 8'(seed + 8'(p * 16 + 3));
    endfunction

    // rotate-mode reference order (R3, R5)
    task automatic a_model(input logic [3:0] m, input logic [7:0] seed);
        logic [3:0] rem = m;
        while (rem != '0) begin
            for (int i = 0; i < 4; i++) begin
                int j;
                j = (a_cur + i) % 4;
                if (rem[j]) begin
                    qa.push_back({6'(seed + 8'(j)), 2'(j), dval(seed, j)});
                    rem[j] = 1'b0;
                    a_cur = (j + 1) % 4;
                    break;
                end
            end
        end
    endtask

    // fixed-mode reference order (R4, R5)
    task automatic b_model(input logic [2:0] m, input logic [7:0] seed);
        for (int j = 0; j < 3; j++) begin
            if (m[j]) qb.push_back({6'(seed + 8'(j)), 2'(j), dval(seed, j)});
        end
    endtask

    task automatic a_drive(input logic [3:0] m, input logic [7:0] seed);
        for (int p = 0; p < 4; p++) begin
            a_rt[p*6 +: 6] = 6'(seed + 8'(p));
            a_rd[p*8 +: 8] = dval(seed, p);
        end
        a_rv = m;
    endtask

    task automatic b_drive(input logic [2:0] m, input logic [7:0] seed);
        for (int p = 0; p < 3; p++) begin
            b_rt[p*6 +: 6] = 6'(seed + 8'(p));
            b_rd[p*8 +: 8] = dval(seed, p);
        end
        b_rv = m;
    endtask

    task automatic a_batch(input logic [3:0] m, input logic [7:0] seed, input bit lat_chk);
        @(negedge clk);
        while (!a_rdy) @(negedge clk);
        a_drive(m, seed);
        a_model(m, seed);
        @(negedge clk);
        a_rv = '0;
        if (lat_chk) begin
            @(negedge clk); #2;
            chk(!a_ov, "R6", "valid too early (A)", 32'(a_ov), 0);
            @(negedge clk); #2;
            chk(a_ov, "R6", "valid after 1+REQ_LAT cycles (A)", 32'(a_ov), 1);
        end
    endtask

    task automatic b_batch(input logic [2:0] m, input logic [7:0] seed, input bit lat_chk);
        @(negedge clk);
        while (!b_rdy) @(negedge clk);
        b_drive(m, seed);
        b_model(m, seed);
        @(negedge clk);
        b_rv = '0;
        if (lat_chk) begin
            #2;
            chk(!b_ov, "R6", "valid too early (B)", 32'(b_ov), 0);
            @(negedge clk); #2;
            chk(b_ov, "R6", "valid after 1+REQ_LAT cycles (B)", 32'(b_ov), 1);
        end
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((qa.size() != 0 || qb.size() != 0) && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        chk(qa.size() == 0, "R1", "A items left over", 32'(qa.size()), 0);
        chk(qb.size() == 0, "R1", "B items left over", 32'(qb.size()), 0);
    endtask

    // monitor A: scoreboard compare and stall hold (R2, R3, R5, R7)
    initial begin
        logic        prev_stall = 1'b0;
        logic [15:0] prev_val = '0;
        forever begin
            @(negedge clk);
            a_ordy = (a_mode == 0) ? 1'b1 : (a_mode == 1) ? 1'b0 : ($urandom % 3 != 0);
            #1;
            if (prev_stall)
                chk(a_ov && {a_ot, a_od} == prev_val, "R7", "A held output",
                    {15'd0, a_ov, a_ot, a_od}, {16'd1, prev_val});
            if (a_ov && a_ordy) begin
                if (qa.size() == 0) chk(1'b0, "R2", "A unexpected request", {a_ot, a_od}, 0);
                else begin
                    logic [15:0] e;
                    e = qa.pop_front();
                    chk({a_ot, a_od} == e, "R3 R5", "A grant order/tag", {a_ot, a_od}, e);
                end
            end
            prev_stall = a_ov && !a_ordy;
            prev_val   = {a_ot, a_od};
        end
    end

    // monitor B (R2, R4, R5, R7)
    initial begin
        logic        prev_stall = 1'b0;
        logic [15:0] prev_val = '0;
        forever begin
            @(negedge clk);
            b_ordy = (b_mode == 0) ? 1'b1 : ($urandom % 2 != 0);
            #1;
            if (prev_stall)
                chk(b_ov && {b_ot, b_od} == prev_val, "R7", "B held output",
                    {15'd0, b_ov, b_ot, b_od}, {16'd1, prev_val});
            if (b_ov && b_ordy) begin
                if (qb.size() == 0) chk(1'b0, "R2", "B unexpected request", {b_ot, b_od}, 0);
                else begin
                    logic [15:0] e;
                    e = qb.pop_front();
                    chk({b_ot, b_od} == e, "R4 R5", "B grant order/tag", {b_ot, b_od}, e);
                end
            end
            prev_stall = b_ov && !b_ordy;
            prev_val   = {b_ot, b_od};
        end
    end

    task automatic a_rsp(input logic [5:0] tag, input logic [1:0] port, input logic [7:0] d);
        @(negedge clk);
        a_sv = 1'b1; a_st = {tag, port}; a_sd = d;
        @(negedge clk);
        a_sv = 1'b0;
        chk(a_pv == (4'b1 << port), "R9", "A response port", 32'(a_pv), 32'(4'b1 << port));
        chk(a_pt == tag && a_pd == d, "R9", "A response tag/data", {a_pt, a_pd}, {tag, d});
        @(negedge clk);
        chk(a_pv == '0, "R9", "A response single pulse", 32'(a_pv), 0);
    endtask

    task automatic b_rsp(input logic [5:0] tag, input logic [1:0] port, input logic [7:0] d);
        logic [2:0] exp;
        exp = (port < 2'd3) ? (3'b1 << port) : 3'b000;
        @(negedge clk);
        b_sv = 1'b1; b_st = {tag, port}; b_sd = d;
        @(negedge clk);
        b_sv = 1'b0;
        if (port < 2'd3) begin
            chk(b_pv == exp, "R9", "B response port", 32'(b_pv), 32'(exp));
            chk(b_pt == tag && b_pd == d, "R9", "B response tag/data", {b_pt, b_pd}, {tag, d});
        end else begin
            chk(b_pv == '0, "R10", "B out-of-range response dropped", 32'(b_pv), 0);
        end
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit saw_low;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!a_ov && a_pv == '0 && a_rdy, "R11", "A reset outputs", {a_ov, a_pv, a_rdy}, 1);
        chk(!b_ov && b_pv == '0 && b_rdy, "R11", "B reset outputs", {b_ov, b_pv, b_rdy}, 1);

        // R6 latency on isolated requests
        a_batch(4'b0100, 8'h30, 1'b1);
        b_batch(3'b010, 8'h31, 1'b1);
        wait_drain();

        // R1 R2 R3: batches queue behind a busy head; cursor wraps from port 3
        a_batch(4'b1111, 8'h10, 1'b0);
        a_batch(4'b0101, 8'h20, 1'b0);
        a_batch(4'b1011, 8'h40, 1'b0);
        a_batch(4'b0110, 8'h50, 1'b0);
        a_batch(4'b1000, 8'h60, 1'b0);
        a_batch(4'b0001, 8'h70, 1'b0);
        // R4: fixed priority regardless of history
        b_batch(3'b111, 8'h11, 1'b0);
        b_batch(3'b110, 8'h21, 1'b0);
        b_batch(3'b101, 8'h41, 1'b0);
        b_batch(3'b011, 8'h51, 1'b0);
        wait_drain();

        // R7: random downstream stalls
        a_mode = 2;
        b_mode = 1;
        for (int k = 0; k < 8; k++) begin
            a_batch(4'(k * 5 + 3), 8'(8'h80 + 8'(k * 4)), 1'b0);
            b_batch(3'(k + 1), 8'(8'h90 + 8'(k * 4)), 1'b0);
        end
        a_mode = 0;
        b_mode = 0;
        wait_drain();

        // R8: fill the queue with the downstream held off
        a_mode = 1;
        saw_low = 1'b0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (!a_rdy) begin
                saw_low = 1'b1;
                break;
            end
            a_drive(4'(1 << (k % 4)), 8'(8'hA0 + 8'(k)));
            a_model(4'(1 << (k % 4)), 8'(8'hA0 + 8'(k)));
            @(negedge clk);
            a_rv = '0;
        end
        chk(saw_low, "R8", "ready low once queue full", 32'(saw_low), 1);
        // R8: presented while not ready, must never appear downstream
        a_drive(4'b1111, 8'hE0);
        @(negedge clk);
        a_rv = '0;
        chk(!a_rdy, "R8", "ready stays low while held off", 32'(a_rdy), 0);
        a_mode = 0;
        wait_drain();

        // R9 R10: response routing
        a_rsp(6'h2A, 2'd3, 8'h77);
        a_rsp(6'h15, 2'd0, 8'h5C);
        b_rsp(6'h33, 2'd2, 8'h19);
        b_rsp(6'h0F, 2'd3, 8'hC4);
        b_rsp(6'h01, 2'd1, 8'h02);

        repeat (4) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule